// File: doc/BRIEF.md
# SDRAM Burst Column Address Sequencer

This block produces the column address for every beat of an SDRAM burst. A burst is armed with a start column, a three-bit burst length code and a one-bit ordering select. The first beat is presented on the cycle after the start pulse. Each `advance` then moves the sequencer to the next beat. A `last_beat` flag marks the final beat of a fixed-length burst. The memory controller and a device-side model share this block, so both compute the same column order.

The low column bits of a burst move inside an aligned block of burst-length columns, whatever the start column is. When the start is unaligned, the address wraps back to the bottom of that block. The column bits above the block stay fixed for the whole burst. Two orderings are available: a sequential count and an interleaved (XOR) order. A full-page burst walks the whole row, modulo the row size. It has no end of its own and runs until `abort` or a new start ends it. Configurations that are reserved or not allowed are refused with a one-cycle error pulse.

Top module: `burst_col_seq`

## Requirements
- R1: While `rst_n` is low and after its release, `col_valid`, `last_beat` and `cfg_err` are 0 until the first start.
- R2: `bl_code` selects the burst length: 3'b000 gives 1, 3'b001 gives 2, 3'b010 gives 4, 3'b011 gives 8, and 3'b111 gives a full page of 2^COL_W columns (256 by default). The codes 3'b100, 3'b101 and 3'b110 are rejected. A rejected start raises `cfg_err` for exactly the following cycle and leaves `col_valid` at 0.
- R3: One cycle after an accepted `start`, `col_valid` is 1 and `col_addr` equals `start_col`.
- R4: With `burst_type` = 0 (sequential), beat i carries low bits (s + i) mod BL, where s is the low bits of the start column. The column bits above the BL-aligned block equal those of `start_col`.
- R5: With `burst_type` = 1 (interleave), beat i carries low bits s XOR i. The upper bits are fixed as in R4.
- R6: A cycle with `advance` high while `col_valid` is 1 steps to the next beat on the following cycle. Without `advance`, the beat and its `col_addr` hold.
- R7: `last_beat` is 1 only while beat BL-1 of a fixed-length burst is presented. An `advance` on that beat drops `col_valid` on the next cycle.
- R8: A full-page burst wraps modulo the row size, never raises `last_beat`, and stays valid until `abort` or a new `start`.
- R9: Interleave ordering combined with the full-page code is rejected as in R2.
- R10: `abort` clears `col_valid` and `cfg_err` on the next cycle. It has priority over `start` and `advance`.
- R11: A `start` while a burst is in progress restarts the sequencer with the new configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start | input | 1 | Arm a new burst with the configuration below |
| start_col | input | COL_W | Column of the first beat |
| bl_code | input | 3 | Burst length code (see R2) |
| burst_type | input | 1 | 0 sequential, 1 interleave |
| advance | input | 1 | Step to the next beat |
| abort | input | 1 | Clear the sequencer |
| col_valid | output | 1 | A beat is being presented |
| col_addr | output | COL_W | Column of the current beat |
| last_beat | output | 1 | Current beat is the final one |
| cfg_err | output | 1 | Previous start was rejected |

## Verification
The embedded assertions watch several rules on every cycle. `last_beat` never appears without a valid beat, and never appears during a full-page burst. The burst ends after an advance on its last beat, and `abort` clears the sequencer. An idle cycle holds the address, a rejected start raises the error, and the first beat equals the start column. Inside the ordering logic, the upper column bits are checked against the start column on every cycle. The actual beat order can only be shown by the bench scenarios, which compare every presented column with a reference computed in the bench. These include the wrap points of unaligned starts, the XOR order, full-page rollover past the top column, and the full set of reserved codes.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

  typedef enum logic [2:0] {
    BLC_1    = 3'b000,
    BLC_2    = 3'b001,
    BLC_4    = 3'b010,
    BLC_8    = 3'b011,
    BLC_PAGE = 3'b111
  } bl_code_e;

  localparam logic ORD_SEQ = 1'b0;
  localparam logic ORD_ILV = 1'b1;

endpackage

// File: rtl/bcs_len_decode.sv
module bcs_len_decode
  import bcs_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic [2:0]       code,
  input  logic             ilv,
  output logic             legal,
  output logic             full,
  output logic [COL_W-1:0] mask
);

  localparam logic [COL_W-1:0] ALL_ONES = '1;

  always_comb begin
    legal = 1'b1;
    full  = 1'b0;
    mask  = '0;
    case (code)
      BLC_1:    mask = '0;
      BLC_2:    mask = COL_W'(1);
      BLC_4:    mask = COL_W'(3);
      BLC_8:    mask = COL_W'(7);
      BLC_PAGE: begin
        full  = 1'b1;
        mask  = ALL_ONES;
        // R9: interleave has no meaning over a whole row
        legal = (ilv == ORD_SEQ);
      end
      default:  legal = 1'b0;
    endcase
  end

  // R2: an accepted length is always a power of two
  always_comb begin
    if (legal) begin
      a_r2_mask_contiguous: assert (((mask + COL_W'(1)) & mask) == '0);
    end
  end

endmodule

// File: rtl/bcs_col_order.sv
module bcs_col_order #(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] idx,
  input  logic [COL_W-1:0] mask,
  input  logic             ilv,
  output logic [COL_W-1:0] col
);

  logic [COL_W-1:0] low_seq;
  logic [COL_W-1:0] low_ilv;
  logic [COL_W-1:0] low_sel;

  always_comb begin
    low_seq = (base + idx) & mask;
    low_ilv = (base ^ idx) & mask;
    low_sel = ilv ? low_ilv : low_seq;
    col     = (base & ~mask) | low_sel;
  end

  // R4 / R5: bits above the aligned block follow the start column
  always_comb begin
    a_r4_upper_fixed: assert (((col ^ base) & ~mask) == '0);
  end

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import bcs_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic [2:0]       bl_code,
  input  logic             burst_type,
  input  logic             advance,
  input  logic             abort,
  output logic             col_valid,
  output logic [COL_W-1:0] col_addr,
  output logic             last_beat,
  output logic             cfg_err
);

  logic             dec_legal;
  logic             dec_full;
  logic [COL_W-1:0] dec_mask;

  logic             valid_q, valid_d;
  logic             err_q,   err_d;
  logic [COL_W-1:0] base_q,  base_d;
  logic [COL_W-1:0] mask_q,  mask_d;
  logic             ilv_q,   ilv_d;
  logic             full_q,  full_d;
  logic [COL_W-1:0] idx_q,   idx_d;
  logic             cfg_en;
  logic             idx_en;
  logic             at_end;

  bcs_len_decode #(.COL_W(COL_W)) u_dec (
    .code  (bl_code),
    .ilv   (burst_type),
    .legal (dec_legal),
    .full  (dec_full),
    .mask  (dec_mask)
  );

  bcs_col_order #(.COL_W(COL_W)) u_ord (
    .base (base_q),
    .idx  (idx_q),
    .mask (mask_q),
    .ilv  (ilv_q),
    .col  (col_addr)
  );

  assign at_end = !full_q && (idx_q == mask_q);

  always_comb begin
    valid_d = valid_q;
    err_d   = 1'b0;
    base_d  = start_col;
    mask_d  = dec_mask;
    ilv_d   = burst_type;
    full_d  = dec_full;
    idx_d   = idx_q;
    cfg_en  = 1'b0;
    idx_en  = 1'b0;
    if (abort) begin
      valid_d = 1'b0;
    end else if (start) begin
      valid_d = dec_legal;
      err_d   = !dec_legal;
      cfg_en  = dec_legal;
      idx_en  = dec_legal;
      idx_d   = '0;
    end else if (advance && valid_q) begin
      if (at_end) begin
        valid_d = 1'b0;
      end else begin
        idx_en = 1'b1;
        idx_d  = idx_q + COL_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      valid_q <= valid_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      mask_q <= '0;
      ilv_q  <= 1'b0;
      full_q <= 1'b0;
    end else if (cfg_en) begin
      base_q <= base_d;
      mask_q <= mask_d;
      ilv_q  <= ilv_d;
      full_q <= full_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (idx_en) begin
      idx_q <= idx_d;
    end
  end

  assign col_valid = valid_q;
  assign last_beat = valid_q && at_end;
  assign cfg_err   = err_q;

  a_r7_last_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    last_beat |-> col_valid);

  a_r8_page_never_last: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && full_q) |-> !last_beat);

  a_r7_end_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (last_beat && advance && !start && !abort) |=> !col_valid);

  a_r10_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!col_valid && !cfg_err));

  a_r6_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && !advance && !start && !abort) |=> (col_valid && $stable(col_addr)));

  a_r2_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !abort && !dec_legal) |=> (cfg_err && !col_valid));

  a_r3_first_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !abort && dec_legal) |=> (col_valid && col_addr == $past(start_col)));

endmodule

// File: tb/burst_col_seq_tb.sv
module burst_col_seq_tb_top;

  localparam int COL_W = 8;
  localparam int ROW   = 256;

  logic             clk;
  logic             rst_n;
  logic             start;
  logic [COL_W-1:0] start_col;
  logic [2:0]       bl_code;
  logic             burst_type;
  logic             advance;
  logic             abort;
  logic             col_valid;
  logic [COL_W-1:0] col_addr;
  logic             last_beat;
  logic             cfg_err;

  int errors;
  int checks;
  bit done;

  // reference state
  bit m_valid;
  bit m_err;
  int m_base;
  int m_len;
  bit m_ilv;
  int m_idx;

  burst_col_seq #(.COL_W(COL_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
    .bl_code(bl_code), .burst_type(burst_type), .advance(advance),
    .abort(abort), .col_valid(col_valid), .col_addr(col_addr),
    .last_beat(last_beat), .cfg_err(cfg_err)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int len_of(input logic [2:0] c);
    case (c)
      3'b000:  return 1;
      3'b001:  return 2;
      3'b010:  return 4;
      3'b011:  return 8;
      3'b111:  return ROW;
      default: return 0;
    endcase
  endfunction

  function automatic int col_of(input int base, input int i, input int len, input bit ilv);
    int s;
    int low;
    s   = base % len;
    low = ilv ? (s ^ i) : ((s + i) % len);
    return (base - s + low) % ROW;
  endfunction

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_model();
    chk(col_valid, m_valid, "R3/R7/R10 col_valid");
    chk(cfg_err, m_err, "R2/R9 cfg_err");
    if (m_valid) begin
      chk(col_addr, col_of(m_base, m_idx, m_len, m_ilv), "R4/R5/R8 col_addr");
      chk(last_beat, (m_len != ROW) && (m_idx == m_len - 1), "R7/R8 last_beat");
    end else begin
      chk(last_beat, 0, "R7 last_beat idle");
    end
  endtask

  task automatic cyc(input bit st, input int sc, input logic [2:0] code,
                     input bit ty, input bit adv, input bit ab);
    int l;
    @(negedge clk);
    start = st; start_col = COL_W'(sc); bl_code = code;
    burst_type = ty; advance = adv; abort = ab;
    @(posedge clk);
    l = len_of(code);
    if (ab) begin
      m_valid = 0; m_err = 0;
    end else if (st) begin
      if (l == 0 || (l == ROW && ty)) begin
        m_valid = 0; m_err = 1;
      end else begin
        m_valid = 1; m_err = 0; m_base = sc; m_len = l; m_ilv = ty; m_idx = 0;
      end
    end else begin
      m_err = 0;
      if (adv && m_valid) begin
        if (m_len != ROW && m_idx == m_len - 1) m_valid = 0;
        else m_idx = (m_idx + 1) % ROW;
      end
    end
    #1;
    check_model();
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
  end

  initial begin
    errors = 0; checks = 0; done = 0;
    m_valid = 0; m_err = 0; m_base = 0; m_len = 1; m_ilv = 0; m_idx = 0;
    start = 0; start_col = '0; bl_code = '0; burst_type = 0; advance = 0; abort = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1;
    chk(col_valid, 0, "R1 valid in reset");
    chk(last_beat, 0, "R1 last in reset");
    chk(cfg_err, 0, "R1 err in reset");
    @(negedge clk); rst_n = 1;
    cyc(0, 0, 3'b000, 0, 1, 0);

    // R4 sequential BL8 from unaligned 0x2D: 2D 2E 2F 28 29 2A 2B 2C
    cyc(1, 8'h2D, 3'b011, 0, 0, 0);
    chk(col_addr, 8'h2D, "R3 first beat");
    cyc(0, 0, 3'b011, 0, 1, 0);
    chk(col_addr, 8'h2E, "R4 seq beat1");
    cyc(0, 0, 3'b011, 0, 1, 0);
    cyc(0, 0, 3'b011, 0, 1, 0);
    chk(col_addr, 8'h28, "R4 seq wrap");
    cyc(0, 0, 3'b011, 0, 0, 0);
    chk(col_addr, 8'h28, "R6 hold");
    for (int k = 0; k < 4; k++) cyc(0, 0, 3'b011, 0, 1, 0);
    chk(col_addr, 8'h2C, "R4 seq last");
    chk(last_beat, 1, "R7 last on beat 7");
    cyc(0, 0, 3'b011, 0, 1, 0);
    chk(col_valid, 0, "R7 end after last");

    // R5 interleave BL8 from 0x2D: 2D 2C 2F 2E 29 28 2B 2A
    cyc(1, 8'h2D, 3'b011, 1, 0, 0);
    cyc(0, 0, 3'b011, 1, 1, 0);
    chk(col_addr, 8'h2C, "R5 ilv beat1");
    cyc(0, 0, 3'b011, 1, 1, 0);
    chk(col_addr, 8'h2F, "R5 ilv beat2");

    // R11 restart mid-burst with BL4 from 0x13: 13 10 11 12
    cyc(1, 8'h13, 3'b010, 0, 1, 0);
    chk(col_addr, 8'h13, "R11 restart");
    cyc(0, 0, 3'b010, 0, 1, 0);
    chk(col_addr, 8'h10, "R11 new config");

    // R2 BL1: last at once
    cyc(1, 8'h77, 3'b000, 0, 0, 0);
    chk(last_beat, 1, "R2 BL1 last");

    // R8 full page from FE: FE FF 00 01, no last
    cyc(1, 8'hFE, 3'b111, 0, 0, 0);
    cyc(0, 0, 3'b111, 0, 1, 0);
    cyc(0, 0, 3'b111, 0, 1, 0);
    chk(col_addr, 8'h00, "R8 page rollover");
    for (int k = 0; k < 300; k++) cyc(0, 0, 3'b111, 0, 1, 0);
    chk(col_valid, 1, "R8 page keeps going");

    // R10 abort beats start
    cyc(1, 8'h05, 3'b011, 0, 1, 1);
    chk(col_valid, 0, "R10 abort priority");

    // R9 interleave full page rejected; R2 reserved codes
    cyc(1, 8'h00, 3'b111, 1, 0, 0);
    chk(cfg_err, 1, "R9 ilv page reject");
    cyc(0, 0, 3'b000, 0, 0, 0);
    chk(cfg_err, 0, "R2 err one cycle");
    for (int c = 4; c < 7; c++) begin
      cyc(1, 8'h10, 3'(c), 0, 0, 0);
      chk(cfg_err, 1, "R2 reserved code");
      chk(col_valid, 0, "R2 reserved no burst");
    end

    // random mix
    void'($urandom(32'd4021));
    for (int k = 0; k < 4000; k++) begin
      cyc(($urandom % 10) == 0, $urandom % ROW, 3'($urandom % 8),
          $urandom % 2, ($urandom % 10) < 7, ($urandom % 40) == 0);
    end

    summary();
  end

endmodule